// File: doc/BRIEF.md
# I2C Target Register Window

This block is an I2C bus target that gives an external controller byte access to a small internal register space. Every transaction opens with a write of a 16-bit register offset, sent least significant byte first. Data bytes that follow in the same write are stored from that offset upward. A read, either after a repeated START or in a new transaction, returns bytes from the current offset upward. The offset steps by one after every data byte in either direction.

The space holds three things. An interrupt status byte is cleared by writing back the value read from it, so a 1 clears a bit. A control byte starts or halts a command interface. A 256-byte data window is backed by local storage. Starting the interface posts a response, which sets a status bit. A level-high interrupt line stays asserted while any status bit is set, so the host must acknowledge the response to drop it.

SCL and SDA are sampled by the system clock through synchronisers. The serial side is run by a state machine with these states:
- `ST_IDLE` waits for a START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` drives the address acknowledge.
- `ST_WR_BYTE` receives a byte.
- `ST_WR_ACK` acknowledges a received byte.
- `ST_RD_BYTE` shifts out a byte.
- `ST_RD_ACK` samples the controller's acknowledge.

The transitions are:
- A START moves any state to `ST_ADDR`, and a STOP moves any state to `ST_IDLE`.
- At the SCL fall that ends the 8th address bit, `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_IDLE` otherwise.
- When the acknowledge clock ends, `ST_ADDR_ACK` goes to `ST_RD_BYTE` for a read and to `ST_WR_BYTE` for a write.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after 8 bits, and `ST_WR_ACK` returns to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after 8 bits.
- `ST_RD_ACK` returns to `ST_RD_BYTE` on an acknowledge, and goes to `ST_IDLE` on a not-acknowledge.

Top module: `i2c_regwin_target`

## Requirements
- R1: After reset `irq` is low and `sda_oe` is low (SDA not driven).
- R2: The target acknowledges only the 7-bit address 0x08 (address byte 0x10 for write, 0x11 for read). Any other address gets no acknowledge and leaves SDA released.
- R3: In a write, the first two data bytes set the offset, low byte first. Every further byte is stored at the offset, which then increments by one.
- R4: A read after a repeated START, or in a new transaction after an offset-only write, returns bytes from consecutive offsets starting at the set offset.
- R5: Offsets 0xF000..0xF0FF map to a 256-byte store indexed by offset bits 7:0. Offset 0xF100 is outside the window, so a write that runs past 0xF0FF does not wrap to 0xF000.
- R6: Offset 0x0006 is the interrupt status byte. A write clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R7: Offset 0x0039 is the control byte. Writing bit 0 as 1 marks the interface running and sets status bit 0. The control byte reads back 0x01 while running and 0x00 otherwise.
- R8: Writing control bit 1 as 1 clears all status bits and the running flag. When bits 0 and 1 are written together, the start wins: status reads 0x01 and control reads 0x01.
- R9: `irq` is high exactly while the status byte is non-zero, and changes only as a result of a register write.
- R10: Reads from offsets outside the three mapped regions return 0x00, and writes to them change nothing.
- R11: The target acknowledges every byte written to it. After the controller does not acknowledge a read byte, the target releases SDA.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| irq | output | 1 | Level-high interrupt, set while any status bit is pending |

## Verification
A single control byte can request a start and a halt at once. The halt clears the status and the start posts a new response in the same register update, so the two compete for status bit 0 and the running flag. The bench provokes this by writing 0x03 to the control offset. It judges the result by reading back status 0x01 and control 0x01 and by seeing `irq` stay high. Writing 0x02 alone must leave both bytes at zero and `irq` low.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } link_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned MSB = STAGES - 1;

    logic [MSB:0] scl_sh, sda_sh;
    logic         scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[MSB-1:0], scl_i};
            sda_sh <= {sda_sh[MSB-1:0], sda_i};
            scl_q  <= scl_sh[MSB];
            sda_q  <= sda_sh[MSB];
        end
    end

    assign scl_s     = scl_sh[MSB];
    assign sda_s     = sda_sh[MSB];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
    import i2ct_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h08,
    parameter int unsigned AW       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam logic [3:0] BITS_FULL = 4'd8;

    link_state_t       state_q, state_d;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [AW-1:0]     ptr_q;
    logic [1:0]        phase_q;
    logic              rw_q, nack_q;
    logic              byte_full, addr_hit;

    assign byte_full = (bit_cnt == BITS_FULL);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign rd_addr   = ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && byte_full) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && byte_full) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = nack_q ? ST_IDLE : ST_RD_BYTE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ptr_q   <= '0;
            phase_q <= '0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                sda_oe <= 1'b0;
            end else if (start_det) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall && byte_full) begin
                            bit_cnt <= '0;
                            if (state_q == ST_ADDR) begin
                                rw_q   <= shreg[0];
                                sda_oe <= addr_hit;
                            end else begin
                                sda_oe <= 1'b1;
                                unique case (phase_q)
                                    2'd0: begin
                                        ptr_q[7:0] <= shreg;
                                        phase_q    <= 2'd1;
                                    end
                                    2'd1: begin
                                        ptr_q[AW-1:8] <= shreg;
                                        phase_q       <= 2'd2;
                                    end
                                    default: begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr_q;
                                        wr_data <= shreg;
                                        ptr_q   <= ptr_q + AW'(1);
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_oe  <= 1'b0;
                                phase_q <= 2'd0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise && !byte_full) bit_cnt <= bit_cnt + 4'd1;
                        if (scl_fall) begin
                            if (byte_full) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                ptr_q   <= ptr_q + AW'(1);
                            end else begin
                                sda_oe <= ~shreg[BYTE_W-1];
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) nack_q <= sda_s;
                        if (scl_fall && !nack_q) begin
                            shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
    import i2ct_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter logic [15:0] IRQ_OFS  = 16'h0006,
    parameter logic [15:0] CTRL_OFS = 16'h0039,
    parameter logic [15:0] WIN_BASE = 16'hF000,
    parameter int unsigned WIN_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] irq_stat,
    output logic              irq
);
    localparam int unsigned DEPTH    = 1 << WIN_LOG2;
    localparam int unsigned GO_BIT   = 0;
    localparam int unsigned HALT_BIT = 1;
    localparam int unsigned RESP_BIT = 0;
    localparam logic [AW-1:0] WIN_TAG = AW'(WIN_BASE) >> WIN_LOG2;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              running;
    logic              wr_win, rd_win;

    assign wr_win = ((wr_addr >> WIN_LOG2) == WIN_TAG);
    assign rd_win = ((rd_addr >> WIN_LOG2) == WIN_TAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_stat <= '0;
            running  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == AW'(IRQ_OFS)) begin
                irq_stat <= irq_stat & ~wr_data;
            end else if (wr_addr == AW'(CTRL_OFS)) begin
                if (wr_data[HALT_BIT]) begin
                    irq_stat <= '0;
                    running  <= 1'b0;
                end
                if (wr_data[GO_BIT]) begin
                    irq_stat[RESP_BIT] <= 1'b1;
                    running            <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_win) mem[wr_addr[WIN_LOG2-1:0]] <= wr_data;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(IRQ_OFS))       rd_data = irq_stat;
        else if (rd_addr == AW'(CTRL_OFS)) rd_data = {{(BYTE_W-1){1'b0}}, running};
        else if (rd_win)                   rd_data = mem[rd_addr[WIN_LOG2-1:0]];
    end

    assign irq = |irq_stat;

endmodule

// File: rtl/i2c_regwin_target.sv
module i2c_regwin_target
    import i2ct_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h08,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [15:0] IRQ_OFS     = 16'h0006,
    parameter logic [15:0] CTRL_OFS    = 16'h0039,
    parameter logic [15:0] WIN_BASE    = 16'hF000,
    parameter int unsigned WIN_LOG2    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic irq
);
    localparam int unsigned AW = 16;

    logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data, irq_stat;

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_link #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    i2ct_regs #(
        .AW(AW), .IRQ_OFS(IRQ_OFS), .CTRL_OFS(CTRL_OFS),
        .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_stat(irq_stat), .irq(irq)
    );

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
    parameter logic [15:0] IRQ_OFS  = 16'h0006,
    parameter logic [15:0] CTRL_OFS = 16'h0039,
    parameter logic [15:0] WIN_BASE = 16'hF000,
    parameter int unsigned WIN_LOG2 = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        irq,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic [7:0]  irq_stat
);
    logic ctrl_wr, stat_wr, unmapped_wr;

    assign ctrl_wr     = wr_en && (wr_addr == CTRL_OFS);
    assign stat_wr     = wr_en && (wr_addr == IRQ_OFS);
    assign unmapped_wr = wr_en && (wr_addr != CTRL_OFS) && (wr_addr != IRQ_OFS)
                         && ((wr_addr >> WIN_LOG2) != (WIN_BASE >> WIN_LOG2));

    // R7: a start request raises the interrupt on the next cycle
    p_go_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && wr_data[0] |=> irq);

    // R8: a halt request alone empties the status
    p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && wr_data[1] && !wr_data[0] |=> (irq_stat == 8'h00) && !irq);

    // R6: bits written as one are cleared
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((irq_stat & $past(wr_data)) == 8'h00));

    // R9: the interrupt line moves only after a register write
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq));

    // R10: writes outside the map leave the status untouched
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_wr |=> $stable(irq_stat));

    // R12: SDA drive begins only while SCL is low
    p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

endmodule

bind i2c_regwin_target i2ct_checker #(
    .IRQ_OFS(IRQ_OFS), .CTRL_OFS(CTRL_OFS), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .irq(irq),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_stat(irq_stat)
);

// File: tb/test_i2c_regwin_target.sv
`timescale 1ns/1ps
module test_i2c_regwin_target;
    localparam time Q = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, irq;
    wire  sda_bus = m_sda & ~sda_oe;
    int   n_chk = 0, n_fail = 0, oe_viol = 0;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    i2c_regwin_target i_i2c_regwin_target (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .irq(irq)
    );

    // R12 monitor: drive changes must fall in SCL low time
    always @(posedge clk) begin
        if (sda_oe !== oe_prev && m_scl) oe_viol++;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
        end
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; ack = !sda_bus; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic rx_byte(input bit nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; m_scl = 1'b1; #Q; b[i] = sda_bus; #Q; m_scl = 1'b0;
        end
        #Q; m_sda = nack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q; m_sda = 1'b1;
    endtask

    // offset then n data bytes, each acknowledge is an R11 check
    task automatic wr_regs(input logic [15:0] ofs, input logic [7:0] d [4], input int n);
        bit ack;
        i2c_start;
        tx_byte(8'h10, ack); check(ack, "R2 addr ack", ack, 1);
        tx_byte(ofs[7:0], ack); check(ack, "R11 ofs lo ack", ack, 1);
        tx_byte(ofs[15:8], ack); check(ack, "R11 ofs hi ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            tx_byte(d[i], ack); check(ack, "R11 data ack", ack, 1);
        end
        i2c_stop;
    endtask

    task automatic rd_regs(input logic [15:0] ofs, input int n, output logic [7:0] q [4]);
        bit ack;
        i2c_start;
        tx_byte(8'h10, ack);
        tx_byte(ofs[7:0], ack);
        tx_byte(ofs[15:8], ack);
        i2c_start;
        tx_byte(8'h11, ack); check(ack, "R2 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) rx_byte(i == n - 1, q[i]);
        #Q; check(!sda_oe, "R11 release after nack", sda_oe, 0);
        i2c_stop;
    endtask

    task automatic t_reset;
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_wrong_addr;
        bit ack;
        i2c_start;
        tx_byte(8'h12, ack);
        check(!ack, "R2 foreign address ignored", ack, 0);
        tx_byte(8'h00, ack);
        check(!ack && !sda_oe, "R2 no drive after miss", ack, 0);
        i2c_stop;
    endtask

    task automatic t_window;
        logic [7:0] q [4];
        wr_regs(16'hF000, '{8'h11, 8'h00, 8'h00, 8'h00}, 1);
        wr_regs(16'hF010, '{8'h5A, 8'hC3, 8'h0F, 8'h7E}, 4);
        rd_regs(16'hF010, 4, q);
        check(q[0] == 8'h5A, "R3 byte0", q[0], 8'h5A);
        check(q[1] == 8'hC3, "R3 byte1", q[1], 8'hC3);
        check(q[2] == 8'h0F, "R4 byte2", q[2], 8'h0F);
        check(q[3] == 8'h7E, "R4 byte3", q[3], 8'h7E);
        wr_regs(16'hF0FF, '{8'hAA, 8'hBB, 8'h00, 8'h00}, 2);
        rd_regs(16'hF0FF, 2, q);
        check(q[0] == 8'hAA, "R5 top byte", q[0], 8'hAA);
        check(q[1] == 8'h00, "R5 past window", q[1], 0);
        rd_regs(16'hF000, 1, q);
        check(q[0] == 8'h11, "R5 no wrap", q[0], 8'h11);
    endtask

    task automatic t_new_xfer_read;
        bit ack;
        logic [7:0] b0, b1;
        logic [7:0] none [4] = '{8'h0, 8'h0, 8'h0, 8'h0};
        wr_regs(16'hF011, none, 0);
        i2c_start;
        tx_byte(8'h11, ack);
        rx_byte(1'b0, b0);
        rx_byte(1'b1, b1);
        i2c_stop;
        check(b0 == 8'hC3, "R4 new xfer byte0", b0, 8'hC3);
        check(b1 == 8'h0F, "R4 new xfer byte1", b1, 8'h0F);
    endtask

    task automatic t_start_ack;
        logic [7:0] q [4];
        wr_regs(16'h0039, '{8'h01, 8'h00, 8'h00, 8'h00}, 1);
        check(irq, "R9 irq after start", irq, 1);
        rd_regs(16'h0006, 1, q);
        check(q[0] == 8'h01, "R7 status", q[0], 1);
        rd_regs(16'h0039, 1, q);
        check(q[0] == 8'h01, "R7 running", q[0], 1);
        wr_regs(16'h0007, '{8'hFF, 8'h00, 8'h00, 8'h00}, 1);
        check(irq, "R10 unmapped write no effect", irq, 1);
        wr_regs(16'h0006, '{8'h00, 8'h00, 8'h00, 8'h00}, 1);
        check(irq, "R6 zero write keeps", irq, 1);
        wr_regs(16'h0006, '{8'h01, 8'h00, 8'h00, 8'h00}, 1);
        check(!irq, "R6 write-back clears", irq, 0);
        rd_regs(16'h0006, 1, q);
        check(q[0] == 8'h00, "R6 status empty", q[0], 0);
    endtask

    task automatic t_halt_and_both;
        logic [7:0] q [4];
        wr_regs(16'h0039, '{8'h01, 8'h00, 8'h00, 8'h00}, 1);
        wr_regs(16'h0039, '{8'h02, 8'h00, 8'h00, 8'h00}, 1);
        check(!irq, "R8 halt drops irq", irq, 0);
        rd_regs(16'h0039, 1, q);
        check(q[0] == 8'h00, "R8 halted", q[0], 0);
        wr_regs(16'h0039, '{8'h03, 8'h00, 8'h00, 8'h00}, 1);
        check(irq, "R8 both bits irq", irq, 1);
        rd_regs(16'h0006, 1, q);
        check(q[0] == 8'h01, "R8 both bits status", q[0], 1);
        rd_regs(16'h0039, 1, q);
        check(q[0] == 8'h01, "R8 both bits running", q[0], 1);
        wr_regs(16'h0006, '{8'h01, 8'h00, 8'h00, 8'h00}, 1);
        check(!irq, "R9 irq low after ack", irq, 0);
    endtask

    task automatic t_unmapped;
        logic [7:0] q [4];
        wr_regs(16'h0100, '{8'h55, 8'h00, 8'h00, 8'h00}, 1);
        rd_regs(16'h0100, 1, q);
        check(q[0] == 8'h00, "R10 unmapped read", q[0], 0);
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 0, 1);
        summary;
    end

    initial begin
        #25;
        t_reset;
        #40 rst_n = 1'b1;
        #(2*Q);
        t_wrong_addr;
        t_window;
        t_new_xfer_read;
        t_start_ack;
        t_halt_and_both;
        t_unmapped;
        check(oe_viol == 0, "R12 drive change with SCL high", oe_viol, 0);
        summary;
    end

endmodule